// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Bank

This block sits behind a 32-bit register bus and controls a one-time-programmable fuse array of 128 words of 32 bits each. Software picks a fuse word through an address field in the control word. It can then sense that word into a result register, or blow bits into it. Blowing is allowed only after a 16-bit unlock key has been placed in the upper half of the control word. Each operation runs through three phases: a relax period, a strobe, and a second relax period. Software sets the length of each phase in a timing register, counted in clock cycles. A busy flag stays high for the whole operation.

The block also holds a bank of shadow registers, one per fuse word. Software can read and write them directly through a window of addresses, and a gap sits in that window between word 0x2F and word 0x30. A refresh command sweeps every fuse word into the shadow bank. The block issues this command by itself right after reset. The fuse array is a behavioural model. Programming ORs new ones into a stored word, so bits can only go from 0 to 1, and the model comes up blank at reset.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Register offsets are: control 0x000, set alias 0x004, clear alias 0x008, timing 0x010, program data 0x020, sense trigger 0x030, sense result 0x040. Timing and the last accepted program data read back as written.
- R2: The control word holds the fuse address in bits 6:0, busy in bit 8, error in bit 9, refresh in bit 10 and the unlock key in bits 31:16. Writing the set alias ORs the written value into the address and key fields. Writing the clear alias clears the written bits of those fields.
- R3: A write to the program data register starts a program operation only if the key field holds 0x3E77. Any other key sets error, and the fuse word and the data register stay unchanged.
- R4: Programming ORs the data into the addressed fuse word, so bits already at 1 stay at 1. The key field returns to zero when the program operation ends.
- R5: Writing the sense trigger with bit 0 set senses the addressed fuse word. The value appears at the sense result register when busy falls. A trigger write with bit 0 clear does nothing.
- R6: Timing fields are: read strobe in bits 21:16, relax in bits 15:12, program strobe in bits 11:0. A sense keeps busy high for exactly 2*relax + read strobe + 3 cycles, and a program for 2*relax + program strobe + 3 cycles.
- R7: Any command issued while busy sets error and is otherwise ignored. A sense that ends with error set leaves 0xBADABADA in the sense result register.
- R8: Error stays set until software writes the clear alias with bit 9 set.
- R9: Writing bit 10 through the control or set alias starts a refresh. Busy and bit 10 then read 1 for exactly 2*relax + 2 + 128*(read strobe + 1) cycles, after which both clear.
- R10: Shadow word n sits at byte offset 0x400 + 16*n for n up to 0x2F, and at 0x500 + 16*n for larger n. Addresses in the gap read 0. A software write to a shadow word changes only the shadow, never the fuse.
- R11: After reset the timing register reads 0x00021004 (read strobe 2, relax 1, program strobe 4) and a refresh starts on the first clock edge.
- R12: A read request returns its data with a valid strobe exactly one cycle later. The valid strobe is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds the answer to the previous cycle's read |

## Verification
Read data is due one cycle after its request. It shows the block's state as it stood after the edge at which the request was made. The bench therefore compares every reply with an expectation queued in the same cycle as the request. Busy and refresh must read 1 in the reply to the k-th read after a command edge exactly when k is less than the operation length from R6 or R9. The bench polls the control word once per cycle and checks each cycle of that window, including the first cycle after it ends. The sense result and the shadow contents are read only after that window has closed.

// File: rtl/otp_pkg.sv
// Shared definitions for the fuse controller: bus offsets, control bit
// positions, the unlock key, phase and operation encodings, timing layout.
package otp_pkg;
    localparam int BUS_AW = 12;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_CSET = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_CCLR = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_TIME = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_DATA = 12'h020;
    localparam logic [BUS_AW-1:0] OFS_TRIG = 12'h030;
    localparam logic [BUS_AW-1:0] OFS_RSLT = 12'h040;
    localparam logic [BUS_AW-1:0] OFS_SHDW = 12'h400;

    localparam int BIT_BUSY    = 8;
    localparam int BIT_ERR     = 9;
    localparam int BIT_REFRESH = 10;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [31:0] SENSE_FAIL = 32'hBADA_BADA;

    typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_STRB, PH_POST} phase_e;
    typedef enum logic [1:0] {OP_SENSE, OP_PROG, OP_SWEEP} op_e;

    typedef struct packed {
        logic [5:0]  rd_strobe;
        logic [3:0]  relax;
        logic [11:0] pg_strobe;
    } timing_t;

    localparam timing_t TIMING_RST = '{rd_strobe: 6'd2, relax: 4'd1, pg_strobe: 12'd4};
endpackage

// File: rtl/otp_seq.sv
// Operation sequencer. It runs relax, strobe and relax phases, each lasting
// its field value plus one cycle. For a sweep it repeats the strobe once per
// word. Assumes start is raised only while idle; timing is latched at start.
module otp_seq import otp_pkg::*; #(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_e           op_in,
    input  timing_t       tim_in,
    output logic          busy,
    output op_e           op_cur,
    output logic          strobe_end,
    output logic [IW-1:0] sweep_idx,
    output logic          op_done
);
    localparam int CW = 12;

    phase_e        ph_q;
    op_e           op_q;
    timing_t       tim_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic          at_zero;
    logic [CW-1:0] strobe_len;

    assign at_zero = (cnt_q == '0);

    // Strobe length picked by the operation in flight
    always_comb strobe_len = (op_q == OP_PROG) ? tim_q.pg_strobe : {6'd0, tim_q.rd_strobe};

    // Phase and counter state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            op_q  <= OP_SENSE;
            tim_q <= '0;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_PRE;
                    op_q  <= op_in;
                    tim_q <= tim_in;
                    cnt_q <= {8'd0, tim_in.relax};
                    idx_q <= '0;
                end
                PH_PRE: if (at_zero) begin
                    ph_q  <= PH_STRB;
                    cnt_q <= strobe_len;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_STRB: if (at_zero) begin
                    if (op_q == OP_SWEEP && !(&idx_q)) begin
                        idx_q <= idx_q + 1'b1;
                        cnt_q <= strobe_len;
                    end else begin
                        ph_q  <= PH_POST;
                        cnt_q <= {8'd0, tim_q.relax};
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: if (at_zero) begin
                    ph_q <= PH_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign busy       = (ph_q != PH_IDLE);
    assign op_cur     = op_q;
    assign strobe_end = (ph_q == PH_STRB) && at_zero;
    assign op_done    = (ph_q == PH_POST) && at_zero;
    assign sweep_idx  = idx_q;

    // R6
    pre_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_PRE) |=> (ph_q == PH_PRE || ph_q == PH_STRB));
    // R7
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ph_q == PH_IDLE));
    // R9
    sweep_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_q == OP_SWEEP) |-> (&idx_q));
endmodule

// File: rtl/otp_fuse_array.sv
// Behavioural fuse array with one read port and an OR-only program port.
// Assumes a blank array at reset, which stands in for unprogrammed silicon.
module otp_fuse_array #(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_addr,
    output logic [31:0]   rd_word,
    input  logic          pg_en,
    input  logic [IW-1:0] pg_addr,
    input  logic [31:0]   pg_bits
);
    localparam int WORDS = 1 << IW;

    logic [31:0] cells [WORDS];

    // Fuse cells: blank at reset, only OR updates afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (pg_en) begin
            cells[pg_addr] <= cells[pg_addr] | pg_bits;
        end
    end

    assign rd_word = cells[rd_addr];

    // R4
    fuse_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_en |=> ((cells[$past(pg_addr)] & $past(cells[pg_addr])) == $past(cells[pg_addr])));
endmodule

// File: rtl/otp_shadow_bank.sv
// Shadow register bank. It decodes the bus window with a gap after word
// GAP_AFTER and is refilled from the fuse array during a sweep. Assumes
// sweep loads take priority over software writes to the same word.
module otp_shadow_bank import otp_pkg::*; #(
    parameter int IW        = 7,
    parameter int GAP_AFTER = 48,
    parameter int GAP_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              hit,
    output logic [31:0]       rd_word,
    input  logic              sw_we,
    input  logic [31:0]       sw_data,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [31:0]       ld_data
);
    localparam int WORDS    = 1 << IW;
    localparam int GAP_SPAN = GAP_BYTES / 16;

    logic [31:0]       words [WORDS];
    logic [BUS_AW-1:0] rel;
    logic [BUS_AW-5:0] raw;
    logic [IW-1:0]     idx;

    // Window decode: 16-byte stride, gap slots unmapped
    always_comb begin
        rel = bus_addr - OFS_SHDW;
        raw = rel[BUS_AW-1:4];
        hit = 1'b0;
        idx = '0;
        if (bus_addr >= OFS_SHDW && rel[3:0] == 4'd0) begin
            if (int'(raw) < GAP_AFTER) begin
                hit = 1'b1;
                idx = IW'(raw);
            end else if (int'(raw) >= GAP_AFTER + GAP_SPAN && int'(raw) - GAP_SPAN < WORDS) begin
                hit = 1'b1;
                idx = IW'(int'(raw) - GAP_SPAN);
            end
        end
    end

    // Shadow storage: sweep load first, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) words[i] <= '0;
        end else if (ld_en) begin
            words[ld_idx] <= ld_data;
        end else if (sw_we && hit) begin
            words[idx] <= sw_data;
        end
    end

    assign rd_word = hit ? words[idx] : '0;
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top of the fuse controller: register decode, key check, error flag, sense
// result and the automatic refresh after reset. Assumes one bus access per
// cycle; read data is registered and answered one cycle after the request.
module otp_fuse_ctrl import otp_pkg::*; #(
    parameter int IW = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid
);
    logic [IW-1:0] addr_q, op_addr_q, fuse_rd_addr, sweep_idx;
    logic [15:0]   key_q;
    logic          err_q, boot_q;
    timing_t       tim_q;
    logic [31:0]   pdata_q, sense_q, rslt_q, rdata_q, fuse_word, shdw_word, ctrl_val, rd_mux;
    logic          rvalid_q;
    logic          wr_ctrl, wr_set, wr_clr, wr_time, wr_data, wr_trig;
    logic          req_prog, req_sense, req_refresh, key_ok, bad_cmd, start;
    logic          busy, strobe_end, op_done, done_prog, done_sense, refresh_on, shdw_hit;
    op_e           op_sel, op_cur;

    // Write decode per register
    assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
    assign wr_set  = bus_wr && bus_addr == OFS_CSET;
    assign wr_clr  = bus_wr && bus_addr == OFS_CCLR;
    assign wr_time = bus_wr && bus_addr == OFS_TIME;
    assign wr_data = bus_wr && bus_addr == OFS_DATA;
    assign wr_trig = bus_wr && bus_addr == OFS_TRIG;

    // Command requests, acceptance and error detection
    assign req_prog    = wr_data;
    assign req_sense   = wr_trig && bus_wdata[0];
    assign req_refresh = (wr_ctrl || wr_set) && bus_wdata[BIT_REFRESH];
    assign key_ok      = (key_q == UNLOCK_KEY);
    assign bad_cmd     = (busy && (req_prog || req_sense || req_refresh))
                      || (!busy && req_prog && !key_ok);
    assign start       = !busy && (boot_q || req_refresh || req_sense || (req_prog && key_ok));
    assign op_sel      = (boot_q || req_refresh) ? OP_SWEEP : (req_prog ? OP_PROG : OP_SENSE);

    assign done_prog  = op_done && op_cur == OP_PROG;
    assign done_sense = op_done && op_cur == OP_SENSE;
    assign refresh_on = busy && op_cur == OP_SWEEP;

    otp_seq #(.IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel), .tim_in(tim_q),
        .busy(busy), .op_cur(op_cur), .strobe_end(strobe_end),
        .sweep_idx(sweep_idx), .op_done(op_done)
    );

    assign fuse_rd_addr = (op_cur == OP_SWEEP) ? sweep_idx : op_addr_q;

    otp_fuse_array #(.IW(IW)) u_fuse (
        .clk(clk), .rst_n(rst_n), .rd_addr(fuse_rd_addr), .rd_word(fuse_word),
        .pg_en(strobe_end && op_cur == OP_PROG), .pg_addr(op_addr_q), .pg_bits(pdata_q)
    );

    otp_shadow_bank #(.IW(IW)) u_shdw (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .hit(shdw_hit), .rd_word(shdw_word),
        .sw_we(bus_wr), .sw_data(bus_wdata),
        .ld_en(strobe_end && op_cur == OP_SWEEP), .ld_idx(sweep_idx), .ld_data(fuse_word)
    );

    // Control fields: address, key, sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            key_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (done_prog) key_q <= '0;
            if (wr_ctrl) begin
                addr_q <= bus_wdata[IW-1:0];
                key_q  <= bus_wdata[31:16];
            end
            if (wr_set) begin
                addr_q <= addr_q | bus_wdata[IW-1:0];
                key_q  <= key_q | bus_wdata[31:16];
            end
            if (wr_clr) begin
                addr_q <= addr_q & ~bus_wdata[IW-1:0];
                key_q  <= key_q & ~bus_wdata[31:16];
                if (bus_wdata[BIT_ERR]) err_q <= 1'b0;
            end
            if (bad_cmd) err_q <= 1'b1;
        end
    end

    // Timing, operation operands, sense result and boot refresh request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q     <= TIMING_RST;
            boot_q    <= 1'b1;
            op_addr_q <= '0;
            pdata_q   <= '0;
            sense_q   <= '0;
            rslt_q    <= '0;
        end else begin
            boot_q <= 1'b0;
            if (wr_time) tim_q <= timing_t'(bus_wdata[21:0]);
            if (start) op_addr_q <= addr_q;
            if (start && req_prog) pdata_q <= bus_wdata;
            if (strobe_end && op_cur == OP_SENSE) sense_q <= fuse_word;
            if (done_sense) rslt_q <= (err_q || bad_cmd) ? SENSE_FAIL : sense_q;
        end
    end

    // Control word image
    always_comb begin
        ctrl_val              = '0;
        ctrl_val[IW-1:0]      = addr_q;
        ctrl_val[BIT_BUSY]    = busy;
        ctrl_val[BIT_ERR]     = err_q;
        ctrl_val[BIT_REFRESH] = refresh_on;
        ctrl_val[31:16]       = key_q;
    end

    // Read decode
    always_comb begin
        case (bus_addr)
            OFS_CTRL, OFS_CSET, OFS_CCLR: rd_mux = ctrl_val;
            OFS_TIME: rd_mux = {10'd0, tim_q};
            OFS_DATA: rd_mux = pdata_q;
            OFS_RSLT: rd_mux = rslt_q;
            default:  rd_mux = shdw_hit ? shdw_word : '0;
        endcase
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_clr && bus_wdata[BIT_ERR])) |=> err_q);
    // R4
    key_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_prog && !wr_ctrl && !wr_set) |=> (key_q == '0));
    // R9
    refresh_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_on |=> (refresh_on || !busy));
    // R12
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
endmodule

// File: tb/test_otp_fuse_ctrl.sv
// Scoreboard bench: read tasks queue expectations, a monitor compares replies.
module test_otp_fuse_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [31:0] q_exp [$];
    logic [31:0] q_msk [$];
    string       q_tag [$];

    localparam logic [31:0] KEY_HI = 32'h3E77_0000;
    localparam logic [31:0] BUSY_B = 32'h0000_0100;
    localparam logic [31:0] RFSH_B = 32'h0000_0500;

    always #4 clk = ~clk;

    otp_fuse_ctrl i_otp_fuse_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic [31:0] msk, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(exp); q_msk.push_back(msk); q_tag.push_back(tag);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    // k-th reply after a command edge shows the state after edge k
    task automatic poll(input int n, input int len, input logic [31:0] bits, input string tag);
        for (int k = 0; k < n; k++) rd(12'h000, (k < len) ? bits : 32'h0, bits, tag);
    endtask

    // Monitor: pops the oldest expectation for each reply
    always @(negedge clk) begin
        if (bus_rvalid && !done_flag) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected reply actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e, m;
                string t;
                e = q_exp.pop_front(); m = q_msk.pop_front(); t = q_tag.pop_front();
                if ((bus_rdata & m) != (e & m)) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, bus_rdata & m, e & m);
                end
            end
        end
    end

    task automatic finish_run();
        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R12 valid low in reset
        if (bus_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R12 rvalid in reset actual %b expected 0", bus_rvalid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R11 boot refresh: 2*1+2+128*3 = 388 cycles, R9
        poll(390, 388, RFSH_B, "R11 boot refresh");
        rd(12'h010, 32'h0002_1004, '1, "R11 timing default");

        // R1 timing readback; new timing relax 2, rd 3, pg 6
        wr(12'h010, 32'h0003_2006);
        rd(12'h010, 32'h0003_2006, '1, "R1 timing readback");
        rd(12'h450, 32'h0, '1, "R10 blank shadow");

        // R3 program with key, R6 length 2*2+6+3 = 13
        wr(12'h000, KEY_HI | 32'h5);
        wr(12'h020, 32'h0000_00F0);
        poll(15, 13, BUSY_B, "R6 program busy");
        rd(12'h000, 32'h0000_0005, '1, "R4 key wiped");
        // R5 sense, R6 length 2*2+3+3 = 10
        wr(12'h030, 32'h1);
        poll(12, 10, BUSY_B, "R6 sense busy");
        rd(12'h040, 32'h0000_00F0, '1, "R5 sense result");

        // R4 OR semantics
        wr(12'h000, KEY_HI | 32'h5);
        wr(12'h020, 32'h0F00_000F);
        poll(14, 13, BUSY_B, "R4 second program busy");
        wr(12'h030, 32'h1);
        poll(11, 10, BUSY_B, "R5 sense busy");
        rd(12'h040, 32'h0F00_00FF, '1, "R4 or result");
        rd(12'h020, 32'h0F00_000F, '1, "R1 data readback");

        // R3 no key: error, no program
        wr(12'h000, 32'h6);
        wr(12'h020, 32'hFFFF_0000);
        rd(12'h000, 32'h0000_0206, '1, "R3 no key error");
        rd(12'h020, 32'h0F00_000F, '1, "R3 data unchanged");
        rd(12'h000, 32'h0000_0206, '1, "R8 error sticky");
        wr(12'h008, 32'h200);
        rd(12'h000, 32'h0000_0006, '1, "R8 error cleared");
        wr(12'h030, 32'h1);
        poll(11, 10, BUSY_B, "R5 sense busy");
        rd(12'h040, 32'h0, '1, "R3 word untouched");

        // R3 wrong key, R2 clear alias on key field
        wr(12'h000, 32'h3E76_0006);
        wr(12'h020, 32'h1);
        rd(12'h000, 32'h3E76_0206, '1, "R3 wrong key error");
        wr(12'h008, 32'h200);
        wr(12'h008, 32'hFFFF_0000);
        rd(12'h000, 32'h0000_0006, '1, "R2 clear alias key");
        wr(12'h030, 32'h1);
        poll(11, 10, BUSY_B, "R5 sense busy");
        rd(12'h040, 32'h0, '1, "R3 wrong key no effect");

        // R7 command while busy
        wr(12'h000, 32'h5);
        wr(12'h030, 32'h1);
        wr(12'h030, 32'h1);
        repeat (12) @(negedge clk);
        rd(12'h000, 32'h0000_0205, '1, "R7 busy collision error");
        rd(12'h040, 32'hBADA_BADA, '1, "R7 failed sense value");
        wr(12'h008, 32'h200);

        // R2 set and clear alias on address
        wr(12'h004, 32'h2);
        rd(12'h000, 32'h0000_0007, '1, "R2 set alias");
        wr(12'h008, 32'h3);
        rd(12'h000, 32'h0000_0004, '1, "R2 clear alias");
        wr(12'h000, 32'h5);
        wr(12'h030, 32'h2);
        rd(12'h000, 32'h0000_0005, '1, "R5 trigger bit0 clear ignored");

        // R10 words on both sides of the gap, then R9 refresh
        wr(12'h000, KEY_HI | 32'h31);
        wr(12'h020, 32'hA5A5_0001);
        poll(14, 13, BUSY_B, "R6 program busy");
        wr(12'h000, KEY_HI | 32'h2F);
        wr(12'h020, 32'h0000_C0DE);
        poll(14, 13, BUSY_B, "R6 program busy");
        // 2*2+2+128*4 = 518
        wr(12'h004, 32'h400);
        poll(520, 518, RFSH_B, "R9 refresh window");
        rd(12'h450, 32'h0F00_00FF, '1, "R10 shadow word 5");
        rd(12'h810, 32'hA5A5_0001, '1, "R10 shadow word 0x31");
        rd(12'h6F0, 32'h0000_C0DE, '1, "R10 shadow word 0x2F");
        rd(12'h700, 32'h0, '1, "R10 gap reads zero");
        rd(12'h710, 32'h0, '1, "R10 gap reads zero");

        // R10 software shadow write leaves fuse alone
        wr(12'h450, 32'h1234_5678);
        rd(12'h450, 32'h1234_5678, '1, "R10 shadow write");
        wr(12'h000, 32'h5);
        wr(12'h030, 32'h1);
        poll(11, 10, BUSY_B, "R5 sense busy");
        rd(12'h040, 32'h0F00_00FF, '1, "R10 fuse unchanged");

        repeat (4) @(negedge clk);
        if (q_exp.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 missing replies actual %0d expected 0", q_exp.size());
        end
        finish_run();
    end
endmodule